// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block translates a guest virtual address into a host physical address for a virtualized system that has no translation caching. The guest table has four levels, and every pointer in it is a guest physical address. Before the walker can read any guest entry, it must translate that entry's address through a four-level host table. The final guest physical address must also pass through the host table. A full walk therefore places a four-level host walk inside each guest step and costs 24 page-table reads.

A request carries the guest virtual address, the frame number of the guest root table and the frame number of the host root table. The walker accepts one request, issues its reads one at a time on a single memory read port, and returns one response. The response holds the host physical address, a fault flag, a flag that says which stage faulted, and the number of reads the walk used.

Top module: `nested_walker`

## Requirements
- R1: After reset, `reqReady` is 1 and both `rspValid` and `memReqValid` are 0.
- R2: The first read of a walk goes to the host top-level entry for the guest top-level entry's address. That guest address is the guest root frame shifted left by 12, plus 8 times guest VA bits [47:39]. The host entry address is the host root frame shifted left by 12, plus 8 times bits [47:39] of that guest address.
- R3: A walk that meets no non-present entry returns `rspFault`=0 and `rspHpa` = {host leaf frame, VA bits [11:0]}. Each entry is 64 bits. Bit 0 is present, and bits [51:12] hold the next frame number. The level-n index is address bits [12+9n +: 9].
- R4: A walk that completes without a fault performs exactly 24 memory reads, and `readCount` reports 24.
- R5: A non-present guest entry ends the walk with `rspFault`=1, `rspFaultHost`=0 and `rspHpa`=0. The read count includes the faulting read.
- R6: A non-present host entry ends the walk with `rspFault`=1, `rspFaultHost`=1 and `rspHpa`=0. The read count includes the faulting read.
- R7: At most one read is outstanding. `memReqValid` stays low until the previous read's data has returned. While a read is held off by `memReqReady`=0, the request and its address stay unchanged.
- R8: `reqReady` stays low from the time a request is accepted until its response is accepted. While `rspReady` is low, the response and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqGva | input | 48 | Guest virtual address |
| reqGuestRoot | input | 40 | Guest-physical frame of the guest top-level table |
| reqHostRoot | input | 40 | Host-physical frame of the host top-level table |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response accepted |
| rspFault | output | 1 | Walk ended on a non-present entry |
| rspFaultHost | output | 1 | Fault came from the host stage |
| rspHpa | output | 52 | Host physical address (zero on fault) |
| readCount | output | 5 | Memory reads used by the latest walk |
| memReqValid | output | 1 | Page-table read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 52 | Host physical byte address of the 64-bit entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry read from memory |

## Verification
Each response arrives a variable number of cycles after the request is accepted, because memory latency and back-pressure stretch every read. For that reason the bench does not count cycles. It samples at falling edges until `rspValid` is high, then checks the response fields. The bench also counts accepted reads at the memory port and checks that total against the expected read count for the path taken: 24 for a full walk, and 5, 20 or 21 for the fault cases. A stalling memory mode and a held-off `rspReady` check that the walker holds its request and its response steady.

// File: rtl/nested_walker_pkg.sv
package nested_walker_pkg;
  typedef struct packed {
    logic capture;
    logic hostAdv;
    logic guestAdv;
    logic markFault;
    logic faultIsHost;
    logic countRead;
    logic selGuest;
  } walkStrobe_t;
endpackage

// File: rtl/nested_walker_datapath.sv
module nested_walker_datapath
  import nested_walker_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  walkStrobe_t              strobe,
  input  logic [VA_W-1:0]          reqGva,
  input  logic [PA_W-PAGE_W-1:0]   reqGuestRoot,
  input  logic [PA_W-PAGE_W-1:0]   reqHostRoot,
  input  logic [63:0]              memRspData,
  output logic [PA_W-1:0]          memReqAddr,
  output logic                     hostLast,
  output logic                     guestFinal,
  output logic                     present,
  output logic [PA_W-1:0]          rspHpa,
  output logic                     rspFault,
  output logic                     rspFaultHost,
  output logic [CNT_W-1:0]         readCount
);
  localparam int FRAME_W = PA_W - PAGE_W;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int STEP_W  = $clog2(LEVELS + 1);
  localparam int SH      = PAGE_W - IDX_W;

  logic [VA_W-1:0]    gvaR;
  logic [FRAME_W-1:0] hostRootR;
  logic [PA_W-1:0]    gpa;
  logic [FRAME_W-1:0] cursor;
  logic [LVL_W-1:0]   hostLvl;
  logic [STEP_W-1:0]  gStep;
  logic [CNT_W-1:0]   readCnt;
  logic               faultR, faultHostR;

  function automatic logic [PA_W-1:0] entryAddr(input logic [FRAME_W-1:0] frame,
                                                input logic [IDX_W-1:0] idx);
    return {frame, {PAGE_W{1'b0}}} | (PA_W'(idx) << SH);
  endfunction

  logic [IDX_W-1:0]   hostIdx, topIdx, guestIdx;
  logic [FRAME_W-1:0] newFrame;
  logic [PA_W-1:0]    nextGpa;
  int                 nxtLvl;

  always_comb begin
    hostIdx  = gpa[PAGE_W + IDX_W*int'(hostLvl) +: IDX_W];
    topIdx   = reqGva[PAGE_W + IDX_W*(LEVELS-1) +: IDX_W];
    nxtLvl   = (int'(gStep) >= LEVELS-1) ? 0 : LEVELS - 2 - int'(gStep);
    guestIdx = gvaR[PAGE_W + IDX_W*nxtLvl +: IDX_W];
    newFrame = memRspData[PA_W-1:PAGE_W];
    if (int'(gStep) == LEVELS-1) nextGpa = {newFrame, gvaR[PAGE_W-1:0]};
    else                         nextGpa = entryAddr(newFrame, guestIdx);
    memReqAddr = strobe.selGuest ? {cursor, gpa[PAGE_W-1:0]} : entryAddr(cursor, hostIdx);
  end

  assign present      = memRspData[0];
  assign hostLast     = (hostLvl == '0);
  assign guestFinal   = (int'(gStep) == LEVELS);
  assign rspHpa       = faultR ? '0 : {cursor, gpa[PAGE_W-1:0]};
  assign rspFault     = faultR;
  assign rspFaultHost = faultHostR;
  assign readCount    = readCnt;

  logic unusedBits;
  assign unusedBits = ^{memRspData[63:PA_W], memRspData[PAGE_W-1:1], gpa[PA_W-1:PAGE_W+IDX_W*LEVELS]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gvaR <= '0; hostRootR <= '0; gpa <= '0; cursor <= '0;
      hostLvl <= '0; gStep <= '0; readCnt <= '0;
      faultR <= 1'b0; faultHostR <= 1'b0;
    end else if (strobe.capture) begin
      gvaR       <= reqGva;
      hostRootR  <= reqHostRoot;
      gpa        <= entryAddr(reqGuestRoot, topIdx);
      cursor     <= reqHostRoot;
      hostLvl    <= LVL_W'(LEVELS-1);
      gStep      <= '0;
      readCnt    <= '0;
      faultR     <= 1'b0;
      faultHostR <= 1'b0;
    end else begin
      if (strobe.countRead) readCnt <= readCnt + 1'b1;
      if (strobe.hostAdv) begin
        cursor  <= newFrame;
        hostLvl <= hostLvl - 1'b1;
      end
      if (strobe.guestAdv) begin
        gpa     <= nextGpa;
        gStep   <= gStep + 1'b1;
        cursor  <= hostRootR;
        hostLvl <= LVL_W'(LEVELS-1);
      end
      if (strobe.markFault) begin
        faultR     <= 1'b1;
        faultHostR <= strobe.faultIsHost;
      end
    end
  end
endmodule

// File: rtl/nested_walker_control.sv
module nested_walker_control
  import nested_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        hostLast,
  input  logic        guestFinal,
  input  logic        present,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        rspValid,
  output logic        memReqValid
);
  typedef enum logic [2:0] {IDLE, HREQ, HWAIT, GREQ, GWAIT, RESP} walkState_t;
  walkState_t state, nextState;

  always_comb begin
    strobe      = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    nextState   = state;
    case (state)
      IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState = HREQ;
        end
      end
      HREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = HWAIT;
      end
      HWAIT: if (memRspValid) begin
        strobe.countRead = 1'b1;
        if (!present) begin
          strobe.markFault   = 1'b1;
          strobe.faultIsHost = 1'b1;
          nextState = RESP;
        end else begin
          strobe.hostAdv = 1'b1;
          if (!hostLast)      nextState = HREQ;
          else if (guestFinal) nextState = RESP;
          else                 nextState = GREQ;
        end
      end
      GREQ: begin
        strobe.selGuest = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) nextState = GWAIT;
      end
      GWAIT: if (memRspValid) begin
        strobe.countRead = 1'b1;
        if (!present) begin
          strobe.markFault = 1'b1;
          nextState = RESP;
        end else begin
          strobe.guestAdv = 1'b1;
          nextState = HREQ;
        end
      end
      RESP: begin
        rspValid = 1'b1;
        if (rspReady) nextState = IDLE;
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= IDLE;
    else        state <= nextState;
  end
endmodule

// File: rtl/nested_walker.sv
module nested_walker
  import nested_walker_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int FRAME_W = PA_W - PAGE_W,
  localparam int CNT_W   = $clog2(LEVELS*(LEVELS+1) + LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqGva,
  input  logic [FRAME_W-1:0] reqGuestRoot,
  input  logic [FRAME_W-1:0] reqHostRoot,
  output logic               rspValid,
  input  logic               rspReady,
  output logic               rspFault,
  output logic               rspFaultHost,
  output logic [PA_W-1:0]    rspHpa,
  output logic [CNT_W-1:0]   readCount,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [63:0]        memRspData
);
  walkStrobe_t strobe;
  logic hostLast, guestFinal, present;

  nested_walker_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .rspReady(rspReady),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .hostLast(hostLast), .guestFinal(guestFinal), .present(present),
    .strobe(strobe), .reqReady(reqReady), .rspValid(rspValid),
    .memReqValid(memReqValid)
  );

  nested_walker_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqGva(reqGva),
    .reqGuestRoot(reqGuestRoot), .reqHostRoot(reqHostRoot),
    .memRspData(memRspData), .memReqAddr(memReqAddr),
    .hostLast(hostLast), .guestFinal(guestFinal), .present(present),
    .rspHpa(rspHpa), .rspFault(rspFault), .rspFaultHost(rspFaultHost),
    .readCount(readCount)
  );
endmodule

// File: rtl/nested_walker_checker.sv
module nested_walker_checker #(
  parameter int PA_W  = 52,
  parameter int CNT_W = 5,
  parameter int FULL_READS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic             rspFault,
  input logic             rspFaultHost,
  input logic [PA_W-1:0]  rspHpa,
  input logic [CNT_W-1:0] readCount,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [PA_W-1:0]  memReqAddr,
  input logic             memRspValid
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (memReqValid && memReqReady) outstanding <= 1'b1;
    else if (memRspValid) outstanding <= 1'b0;
  end

  assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !memReqValid);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspHpa) && $stable(rspFault)
                                 && $stable(rspFaultHost) && $stable(readCount)));
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid || memReqValid) |-> !reqReady);
  assert_full_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspFault) |-> (int'(readCount) == FULL_READS));
  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspFault) |-> (rspHpa == '0));
endmodule

bind nested_walker nested_walker_checker #(.PA_W(PA_W), .CNT_W(CNT_W),
  .FULL_READS(LEVELS*(LEVELS+1) + LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqReady(reqReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspFault(rspFault), .rspFaultHost(rspFaultHost),
  .rspHpa(rspHpa), .readCount(readCount), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid)
);

// File: tb/nested_walker_test.sv
module nested_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reqValid = 1'b0, reqReady, rspValid, rspReady = 1'b0;
  logic [47:0] reqGva = '0;
  logic [39:0] reqGuestRoot = '0, reqHostRoot = '0;
  logic        rspFault, rspFaultHost;
  logic [51:0] rspHpa;
  logic [4:0]  readCount;
  logic        memReqValid, memReqReady = 1'b1, memRspValid = 1'b0;
  logic [51:0] memReqAddr;
  logic [63:0] memRspData = '0;

  nested_walker uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqGva(reqGva), .reqGuestRoot(reqGuestRoot), .reqHostRoot(reqHostRoot),
    .rspValid(rspValid), .rspReady(rspReady), .rspFault(rspFault),
    .rspFaultHost(rspFaultHost), .rspHpa(rspHpa), .readCount(readCount),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  localparam logic [39:0] GROOT = 40'h100;
  localparam logic [39:0] HROOT = 40'h2000;

  logic [63:0] mem [logic [51:0]];
  logic [39:0] gp2hp [logic [39:0]];
  logic [39:0] hostAlloc = 40'h3000;
  logic [39:0] guestAlloc = 40'h200;
  int nChecks = 0, nFails = 0;
  logic stallMode = 1'b0;
  int readsSeen = 0;
  logic firstSeen = 1'b0;
  logic [51:0] firstAddr = '0;

  // memory model: one-cycle read latency, optional request stalls
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    memReqReady <= stallMode ? ~memReqReady : 1'b1;
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= mem.exists(memReqAddr) ? mem[memReqAddr] : 64'h0;
      readsSeen   <= readsSeen + 1;
      if (!firstSeen) begin
        firstSeen <= 1'b1;
        firstAddr <= memReqAddr;
      end
    end
  end

  function automatic logic [63:0] mkEntry(input logic [39:0] frame);
    return (64'(frame) << 12) | 64'h1;
  endfunction

  function automatic logic [51:0] slot(input logic [39:0] tbl, input logic [8:0] idx);
    return {tbl, 12'h0} + 52'(idx) * 8;
  endfunction

  task automatic hostMap(input logic [39:0] gFrame, input logic [39:0] hFrame);
    logic [39:0] tbl = HROOT;
    for (int lvl = 3; lvl >= 1; lvl--) begin
      logic [51:0] a = slot(tbl, gFrame[9*lvl +: 9]);
      if (!mem.exists(a)) begin
        mem[a] = mkEntry(hostAlloc);
        hostAlloc = hostAlloc + 1;
      end
      tbl = mem[a][51:12];
    end
    mem[slot(tbl, gFrame[8:0])] = mkEntry(hFrame);
    gp2hp[gFrame] = hFrame;
  endtask

  task automatic guestMap(input logic [35:0] vpn, input logic [39:0] gFrame);
    logic [39:0] tbl = GROOT;
    for (int lvl = 3; lvl >= 1; lvl--) begin
      logic [51:0] a = slot(gp2hp[tbl], vpn[9*lvl +: 9]);
      if (!mem.exists(a)) begin
        mem[a] = mkEntry(guestAlloc);
        hostMap(guestAlloc, hostAlloc);
        hostAlloc = hostAlloc + 1;
        guestAlloc = guestAlloc + 1;
      end
      tbl = mem[a][51:12];
    end
    mem[slot(gp2hp[tbl], vpn[8:0])] = mkEntry(gFrame);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  task automatic runWalk(input string req, input logic [47:0] gva, input logic fExp,
                         input logic fHostExp, input logic [51:0] hpaExp,
                         input int readsExp, input int hold);
    logic [51:0] hpaSeen;
    @(negedge clk);
    firstSeen = 1'b0; readsSeen = 0;
    chk(req, "reqReady idle", 64'(reqReady), 64'h1);
    reqValid = 1'b1; reqGva = gva; reqGuestRoot = GROOT; reqHostRoot = HROOT;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    chk(req, "fault", 64'(rspFault), 64'(fExp));
    chk(req, "faultHost", 64'(rspFaultHost), 64'(fHostExp));
    chk(req, "hpa", 64'(rspHpa), 64'(hpaExp));
    chk(req, "readCount", 64'(readCount), 64'(readsExp));
    chk(req, "reads at port", 64'(readsSeen), 64'(readsExp));
    hpaSeen = rspHpa;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R8", "rspValid held", 64'(rspValid), 64'h1);
      chk("R8", "reqReady low while busy", 64'(reqReady), 64'h0);
      chk("R8", "hpa stable", 64'(rspHpa), 64'(hpaSeen));
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(req, "idle after response", 64'(reqReady), 64'h1);
  endtask

  function automatic logic [51:0] expHpa(input logic [39:0] gFrame, input logic [47:0] gva);
    return {gp2hp[gFrame], gva[11:0]};
  endfunction

  localparam logic [47:0] GVA_A = 48'h0012_3456_7ABC;
  localparam logic [47:0] GVA_B = 48'h7F00_0000_1111;
  localparam logic [47:0] GVA_C = 48'h0012_3456_9DEF;
  localparam logic [47:0] GVA_D = 48'h4000_0000_0042;
  localparam logic [39:0] DATA_A = 40'h7000;
  localparam logic [39:0] DATA_B = 40'h7123;
  localparam logic [39:0] DATA_C = 40'h0F800_0000;

  task automatic testReset;
    @(negedge clk);
    chk("R1", "reqReady", 64'(reqReady), 64'h1);
    chk("R1", "rspValid", 64'(rspValid), 64'h0);
    chk("R1", "memReqValid", 64'(memReqValid), 64'h0);
  endtask

  task automatic testFullWalk;
    logic [51:0] gTop = {GROOT, 12'h0} + 52'(GVA_A[47:39]) * 8;
    logic [51:0] hFirst = {HROOT, 12'h0} + 52'(gTop[47:39]) * 8;
    runWalk("R3", GVA_A, 1'b0, 1'b0, expHpa(DATA_A, GVA_A), 24, 0);
    chk("R2", "first read address", 64'(firstAddr), 64'(hFirst));
    chk("R4", "full walk count", 64'(readCount), 64'd24);
  endtask

  task automatic testStalledWalk;
    stallMode = 1'b1;
    runWalk("R7", GVA_B, 1'b0, 1'b0, expHpa(DATA_B, GVA_B), 24, 0);
    stallMode = 1'b0;
  endtask

  task automatic testGuestFaults;
    runWalk("R5", GVA_D, 1'b1, 1'b0, 52'h0, 5, 0);
    runWalk("R5", GVA_A + 48'h1000, 1'b1, 1'b0, 52'h0, 20, 0);
  endtask

  task automatic testHostFault;
    runWalk("R6", GVA_C, 1'b1, 1'b1, 52'h0, 21, 0);
  endtask

  task automatic testBackpressure;
    runWalk("R8", GVA_A, 1'b0, 1'b0, expHpa(DATA_A, GVA_A), 24, 5);
  endtask

  initial begin
    hostMap(GROOT, 40'h2100);
    hostMap(DATA_A, 40'h5_0000);
    hostMap(DATA_B, 40'h5_1234);
    guestMap(GVA_A[47:12], DATA_A);
    guestMap(GVA_B[47:12], DATA_B);
    guestMap(GVA_C[47:12], DATA_C);   // data frame left without a host mapping
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    testReset();
    testFullWalk();
    testStalledWalk();
    testGuestFaults();
    testHostFault();
    testBackpressure();
    testFullWalk();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end
endmodule